// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge Interrupts

This block is the register-mapped controller for one eight-pin general-purpose I/O port. Software owns an output data register that it can load whole, or change bit by bit through three write-only alias offsets (OR-in, clear-where-one, toggle-where-one). Software never needs a read-modify-write sequence for this. The block drives the output register straight onto `out_data`.

On the input side, each pad passes through a two-flop synchronizer. The synchronized level is then qualified per pin by a stored 3-bit drive-mode field and an input-disable bit. Software can read the qualified level. A per-pin 2-bit edge selector picks which transitions of that level set a sticky pending flag. Software clears a flag by writing 1 to it. The OR of all flags forms the single port interrupt request.

The register bus is a simple one-cycle write strobe with combinational read data. `addr` selects a word register.

Top module: `gpio_edge_port`

## Requirements
- R1: After synchronous reset, all of the following are zero: the output data, the drive-mode register, the edge-select register, the input-disable register, all pending flags and `irq`.
- R2: A write to offset 0x0 replaces all eight output bits with `wdata[7:0]`, and `out_data` shows the new value from the next clock edge.
- R3: A write to offset 0x6 ORs `wdata[7:0]` into the output data register.
- R4: A write to offset 0x7 clears every output bit where `wdata` has a 1 and leaves the other bits unchanged.
- R5: A write to offset 0x8 toggles every output bit where `wdata` has a 1 and leaves the other bits unchanged.
- R6: Offset 0x1 reads the pad levels after a two-flop synchronizer, so a pad change becomes visible after the second rising clock edge and not after the first.
- R7: Pin n's drive-mode field is bits [3n+2:3n] of offset 0x2. When that field is 0, pin n reads 0 at offset 0x1 and raises no pending flag, whatever the pad level.
- R8: Bit n of offset 0x5 disables pin n's input. The pin then reads 0 and raises no pending flag for any drive mode.
- R9: Pin n's edge selector is bits [2n+1:2n] of offset 0x3, with the codes 0 = none, 1 = rising, 2 = falling, 3 = both. A selected edge sets pending bit n on the third rising clock edge after the pad changes, and each edge sets the bit once.
- R10: Pending flags read at offset 0x4, bit n for pin n. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: `irq` is high exactly when at least one pending flag is set.
- R12: If a selected edge and a write-1-to-clear of the same pin land on the same clock edge, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Word register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pad_in | input | 8 | Raw pad levels |
| out_data | output | 8 | Output data register |
| irq | output | 1 | Combined port interrupt request |

## Verification
The hardest case to reach is the collision between an edge and a clear. The synchronizer delay places the internal edge strobe in a cycle the ports do not show directly. The bench changes the pad on a falling clock edge and waits two rising edges. It then presents a write-1-to-clear for that pin, so the write and the edge strobe take effect on the same third rising edge, and it checks that the flag survives. The gating cases are also checked: a drive mode of 0 and input-disable, each applied to a pin whose edge selector is armed.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W  = 4;
    localparam int MODE_W  = 3;
    localparam int EDGE_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_OUT   = 4'h0,
        REG_PAD   = 4'h1,
        REG_MODE  = 4'h2,
        REG_EDGE  = 4'h3,
        REG_PEND  = 4'h4,
        REG_INDIS = 4'h5,
        REG_SET   = 4'h6,
        REG_CLR   = 4'h7,
        REG_INV   = 4'h8
    } reg_idx_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR,
        OP_INV
    } out_op_e;

    typedef enum logic [EDGE_W-1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    localparam logic [MODE_W-1:0] MODE_HIZ_ANALOG = '0;

    function automatic logic edge_hit(input edge_sel_e sel, input logic cur, input logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (sel)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_ANY:  edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

    function automatic out_op_e decode_out_op(input logic we, input logic [ADDR_W-1:0] addr);
        decode_out_op = OP_NONE;
        if (we) begin
            case (addr)
                REG_OUT: decode_out_op = OP_LOAD;
                REG_SET: decode_out_op = OP_SET;
                REG_CLR: decode_out_op = OP_CLR;
                REG_INV: decode_out_op = OP_INV;
                default: decode_out_op = OP_NONE;
            endcase
        end
    endfunction

endpackage

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  out_op_e         op_i,
    input  logic [PINS-1:0] bits_i,
    output logic [PINS-1:0] out_o
);

    logic [PINS-1:0] out_q;
    logic [PINS-1:0] out_d;

    always_comb begin
        out_d = out_q;
        case (op_i)
            OP_LOAD: out_d = bits_i;
            OP_SET:  out_d = out_q | bits_i;
            OP_CLR:  out_d = out_q & ~bits_i;
            OP_INV:  out_d = out_q ^ bits_i;
            default: out_d = out_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_o = out_q;

    AST_LOAD_REPLACES: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_LOAD) |=> (out_o == $past(bits_i)));                       // R2
    AST_SET_ORS: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SET) |=> (out_o == ($past(out_o) | $past(bits_i))));        // R3
    AST_CLR_MASKS: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CLR) |=> (out_o == ($past(out_o) & ~$past(bits_i))));       // R4
    AST_INV_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_INV) |=> (out_o == ($past(out_o) ^ $past(bits_i))));        // R5

endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8,
    localparam int MODE_BITS = PINS * MODE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PINS-1:0]      pad_i,
    input  logic [MODE_BITS-1:0] mode_i,
    input  logic [PINS-1:0]      indis_i,
    output logic [PINS-1:0]      cur_o,
    output logic [PINS-1:0]      prev_o,
    output logic [PINS-1:0]      en_o,
    output logic [PINS-1:0]      state_o
);

    logic [PINS-1:0] meta_q;
    logic [PINS-1:0] sync_q;
    logic [PINS-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pad_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign en_o[p]    = (mode_i[p*MODE_W +: MODE_W] != MODE_HIZ_ANALOG) && !indis_i[p];
        assign state_o[p] = sync_q[p] & en_o[p];

        AST_GATED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
            (indis_i[p] || (mode_i[p*MODE_W +: MODE_W] == MODE_HIZ_ANALOG)) |-> !state_o[p]); // R7
        AST_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
            en_o[p] && $past(!rst) |-> (state_o[p] == $past(meta_q[p])));                    // R6
    end

    assign cur_o  = sync_q;
    assign prev_o = hist_q;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8,
    localparam int EDGE_BITS = PINS * EDGE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PINS-1:0]      cur_i,
    input  logic [PINS-1:0]      prev_i,
    input  logic [PINS-1:0]      en_i,
    input  logic [EDGE_BITS-1:0] edge_cfg_i,
    input  logic [PINS-1:0]      clr_i,
    output logic [PINS-1:0]      pend_o,
    output logic                 irq_o
);

    logic [PINS-1:0] hit;
    logic [PINS-1:0] pend_q;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        edge_sel_e sel;
        assign sel    = edge_sel_e'(edge_cfg_i[p*EDGE_W +: EDGE_W]);
        assign hit[p] = en_i[p] & edge_hit(sel, cur_i[p], prev_i[p]);

        always_ff @(posedge clk) begin
            if (rst)         pend_q[p] <= 1'b0;
            else if (hit[p]) pend_q[p] <= 1'b1;
            else if (clr_i[p]) pend_q[p] <= 1'b0;
        end

        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
            hit[p] |=> pend_o[p]);                                   // R12
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (clr_i[p] && !hit[p]) |=> !pend_o[p]);                   // R10
        AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_o[p]) |-> $past(hit[p]));                     // R9
        AST_GATED_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
            !en_i[p] |=> !$rose(pend_o[p]));                         // R8
    end

    assign pend_o = pend_q;
    assign irq_o  = |pend_q;

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(|clr_i));                             // R11

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int PINS = 8,
    parameter int DW   = 32,
    localparam int MODE_BITS = PINS * MODE_W,
    localparam int EDGE_BITS = PINS * EDGE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] out_data,
    output logic            irq
);

    logic [MODE_BITS-1:0] mode_q;
    logic [EDGE_BITS-1:0] edge_q;
    logic [PINS-1:0]      indis_q;
    logic [PINS-1:0]      cur, prev, en, state, pend, clr;
    out_op_e              op;

    assign op  = decode_out_op(we, addr);
    assign clr = (we && addr == REG_PEND) ? wdata[PINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            edge_q  <= '0;
            indis_q <= '0;
        end else if (we) begin
            case (addr)
                REG_MODE:  mode_q  <= wdata[MODE_BITS-1:0];
                REG_EDGE:  edge_q  <= wdata[EDGE_BITS-1:0];
                REG_INDIS: indis_q <= wdata[PINS-1:0];
                default: ;
            endcase
        end
    end

    gpio_out_reg #(.PINS(PINS)) u_out (
        .clk(clk), .rst(rst), .op_i(op), .bits_i(wdata[PINS-1:0]), .out_o(out_data)
    );

    gpio_in_path #(.PINS(PINS)) u_in (
        .clk(clk), .rst(rst), .pad_i(pad_in), .mode_i(mode_q), .indis_i(indis_q),
        .cur_o(cur), .prev_o(prev), .en_o(en), .state_o(state)
    );

    gpio_edge_irq #(.PINS(PINS)) u_irq (
        .clk(clk), .rst(rst), .cur_i(cur), .prev_i(prev), .en_i(en),
        .edge_cfg_i(edge_q), .clr_i(clr), .pend_o(pend), .irq_o(irq)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            REG_OUT:   rdata = DW'(out_data);
            REG_PAD:   rdata = DW'(state);
            REG_MODE:  rdata = DW'(mode_q);
            REG_EDGE:  rdata = DW'(edge_q);
            REG_PEND:  rdata = DW'(pend);
            REG_INDIS: rdata = DW'(indis_q);
            default:   rdata = '0;
        endcase
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (out_data == '0 && !irq && mode_q == '0 && edge_q == '0)); // R1

endmodule

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  out_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_port uut (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .out_data(out_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pad_step(input logic [7:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h0, d); check("R1 out", d, 0);
        rd(4'h2, d); check("R1 mode", d, 0);
        rd(4'h3, d); check("R1 edge", d, 0);
        rd(4'h4, d); check("R1 pend", d, 0);
        rd(4'h5, d); check("R1 indis", d, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_output();
        wr(4'h0, 32'hA5); check("R2 load", {24'd0, out_data}, 32'hA5);
        wr(4'h0, 32'h3C); check("R2 replace", {24'd0, out_data}, 32'h3C);
        wr(4'h6, 32'h81); check("R3 set", {24'd0, out_data}, 32'hBD);
        wr(4'h7, 32'h0F); check("R4 clear", {24'd0, out_data}, 32'hB0);
        wr(4'h8, 32'hF1); check("R5 invert", {24'd0, out_data}, 32'h41);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        @(negedge clk);
        pad_in = 8'h80;
        @(posedge clk);
        rd(4'h1, d); check("R6 one edge old", d, 0);
        @(posedge clk);
        rd(4'h1, d); check("R6 two edges new", d, 32'h80);
        pad_step(8'h00);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        pad_step(8'h3F);
        rd(4'h1, d); check("R7 R8 pad gating", d, 32'h0F);
        rd(4'h4, d); check("R9 rising/both/gated", d, 32'h05);
        check("R11 irq high", {31'd0, irq}, 1);
        wr(4'h4, 32'hFF);
        rd(4'h4, d); check("R10 clear all", d, 0);
        check("R11 irq low", {31'd0, irq}, 0);
        pad_step(8'h00);
        rd(4'h4, d); check("R9 falling/both", d, 32'h06);
        wr(4'h4, 32'h02);
        rd(4'h4, d); check("R10 partial clear", d, 32'h04);
        wr(4'h4, 32'h00);
        rd(4'h4, d); check("R10 zero no effect", d, 32'h04);
        repeat (4) @(posedge clk);
        rd(4'h4, d); check("R9 single set per edge", d, 32'h04);
        wr(4'h4, 32'h04);
        check("R11 irq after clear", {31'd0, irq}, 0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        pad_step(8'h05);
        rd(4'h4, d); check("R9 setup", d, 32'h05);
        @(negedge clk);
        pad_in = 8'h01;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        we = 1'b1; addr = 4'h4; wdata = 32'h04;
        @(negedge clk);
        we = 1'b0; wdata = '0;
        rd(4'h4, d); check("R12 edge wins clear", d, 32'h05);
        wr(4'h4, 32'hFF);
        rd(4'h4, d); check("R10 final clear", d, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_output();
        wr(4'h2, 32'h249249 & ~(32'h7 << 12));
        wr(4'h3, 32'h539);
        wr(4'h5, 32'h20);
        t_sync();
        wr(4'h4, 32'hFF);
        t_edges();
        t_collision();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule